// File: doc/BRIEF.md
# Master/Slave Access Window Tracker

This block keeps a direct-mapped, untagged table of access counters that follows how far a master core has run ahead of its redundant slave. Each master load or store adds one to the entry chosen by its address. Each matching slave access removes one. An entry whose count is non-zero is an open window: the master has touched that location and the slave has not yet caught up.

Requests from remote nodes are checked against the table in the same cycle. A remote write to an entry with an open window gets a stall response. A remote read is always allowed. Different addresses that map to the same entry share its counter. When a counter reaches its ceiling, further master accesses to that entry are stalled. A clear input, used on rollback, empties the whole table in one cycle.

Top module: `access_window_table`

## Requirements
- R1: The entry index is address bits [WORD_OFS+IDX_W-1:WORD_OFS] (defaults: bits [7:2] of 64 entries). Addresses with equal index bits share one counter.
- R2: A master access that is not stalled adds one to its entry's count from the next cycle on.
- R3: A slave access to an entry with a non-zero count subtracts one from it from the next cycle on. A slave access to an entry whose count is zero is ignored and leaves the count at zero.
- R4: remAllow is low in the same cycle when remValid and remWrite are high and the indexed entry's count is non-zero. It is high when that count is zero.
- R5: A remote read (remValid high, remWrite low) always sees remAllow high.
- R6: When the indexed entry holds the maximum count (2^CNT_W-1, default 255), mstStall is high in the same cycle and the access leaves the count unchanged. In every other case mstStall is low.
- R7: A cycle with clear high makes every count zero from the next cycle on. This takes precedence over master and slave accesses in that same cycle.
- R8: A master access and a slave access to the same entry in one cycle, where the count is between 1 and maximum-1, leave that count unchanged.
- R9: After reset every count is zero, so remote writes to any entry are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the whole table (rollback) |
| mstValid | input | 1 | Master access this cycle |
| mstAddr | input | ADDR_W | Master access address |
| mstStall | output | 1 | Master access refused (counter full) |
| slvValid | input | 1 | Slave access this cycle |
| slvAddr | input | ADDR_W | Slave access address |
| remValid | input | 1 | Remote request present |
| remAddr | input | ADDR_W | Remote request address |
| remWrite | input | 1 | Remote request is a write |
| remAllow | output | 1 | Remote request may proceed |

## Verification
Both mstStall and remAllow are combinational views of the registered counts, so each one is due in the same cycle as the request that asks for it. A master, slave or clear action changes what those outputs show from the following cycle on. The bench drives inputs on the falling edge and compares the outputs shortly after. Its behavioural model updates on the rising edge, so every comparison uses the counts committed by the previous edge, which matches the one-cycle latency of the table. Directed sequences cover aliasing, underflow, saturation, same-cycle master/slave pairs and clear priority. A long random mix is then compared on every cycle.

// File: rtl/awt_pkg.sv
package awt_pkg;
  // Strobes issued by the control to the counter datapath
  typedef struct packed {
    logic inc;   // count up the master entry
    logic dec;   // count down the slave entry
    logic clr;   // zero every entry
  } awtStrobe_t;
endpackage

// File: rtl/awt_datapath.sv
module awt_datapath
  import awt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  awtStrobe_t       strobe,
  input  logic [IDX_W-1:0] mstIdx,
  input  logic [IDX_W-1:0] slvIdx,
  input  logic [IDX_W-1:0] remIdx,
  output logic [CNT_W-1:0] mstCount,
  output logic [CNT_W-1:0] slvCount,
  output logic [CNT_W-1:0] remCount
);
  logic [CNT_W-1:0] cnt [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic hitInc, hitDec;
    assign hitInc = strobe.inc && (mstIdx == IDX_W'(i));
    assign hitDec = strobe.dec && (slvIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt[i] <= '0;
      else if (strobe.clr)       cnt[i] <= '0;
      else if (hitInc && !hitDec) cnt[i] <= cnt[i] + 1'b1;
      else if (hitDec && !hitInc) cnt[i] <= cnt[i] - 1'b1;
    end

    // R2: a lone master strobe raises this entry by one
    p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hitInc && !hitDec && !strobe.clr) |=> cnt[i] == $past(cnt[i]) + 1'b1);
    // R3: a lone slave strobe lowers this entry by one
    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hitDec && !hitInc && !strobe.clr) |=> cnt[i] == $past(cnt[i]) - 1'b1);
    // R7: clear empties the entry
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.clr |=> cnt[i] == '0);
  end

  assign mstCount = cnt[mstIdx];
  assign slvCount = cnt[slvIdx];
  assign remCount = cnt[remIdx];
endmodule

// File: rtl/awt_control.sv
module awt_control
  import awt_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             mstValid,
  input  logic [CNT_W-1:0] mstCount,
  input  logic             slvValid,
  input  logic [CNT_W-1:0] slvCount,
  input  logic             remValid,
  input  logic             remWrite,
  input  logic [CNT_W-1:0] remCount,
  output awtStrobe_t       strobe,
  output logic             mstStall,
  output logic             remAllow
);
  logic mstFull, slvOpen, remOpen;

  assign mstFull = (mstCount == CNT_MAX);
  assign slvOpen = (slvCount != '0);
  assign remOpen = (remCount != '0);

  assign mstStall   = mstValid && mstFull;
  assign remAllow   = !(remValid && remWrite && remOpen);

  always_comb begin
    strobe     = '0;
    strobe.clr = clear;
    strobe.inc = mstValid && !mstFull && !clear;
    strobe.dec = slvValid && slvOpen && !clear;
  end

  // R6: never count past the ceiling
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.inc |-> mstCount != CNT_MAX);
  // R3: never count below zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dec |-> slvCount != '0);
  // R5: remote reads are never held
  p_read_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (remValid && !remWrite) |-> remAllow);
  // R7: clear blocks counting in its cycle
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !(strobe.inc || strobe.dec));
endmodule

// File: rtl/access_window_table.sv
module access_window_table
  import awt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 64,
  parameter int WORD_OFS = 2,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mstValid,
  input  logic [ADDR_W-1:0] mstAddr,
  output logic              mstStall,
  input  logic              slvValid,
  input  logic [ADDR_W-1:0] slvAddr,
  input  logic              remValid,
  input  logic [ADDR_W-1:0] remAddr,
  input  logic              remWrite,
  output logic              remAllow
);
  // R1: direct-mapped, untagged index selection
  logic [IDX_W-1:0] mstIdx, slvIdx, remIdx;
  assign mstIdx = mstAddr[WORD_OFS +: IDX_W];
  assign slvIdx = slvAddr[WORD_OFS +: IDX_W];
  assign remIdx = remAddr[WORD_OFS +: IDX_W];

  awtStrobe_t       strobe;
  logic [CNT_W-1:0] mstCount, slvCount, remCount;

  awt_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .mstValid(mstValid), .mstCount(mstCount),
    .slvValid(slvValid), .slvCount(slvCount),
    .remValid(remValid), .remWrite(remWrite), .remCount(remCount),
    .strobe(strobe), .mstStall(mstStall), .remAllow(remAllow)
  );

  awt_datapath #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .mstIdx(mstIdx), .slvIdx(slvIdx), .remIdx(remIdx),
    .mstCount(mstCount), .slvCount(slvCount), .remCount(remCount)
  );
endmodule

// File: tb/access_window_table_bench.sv
module access_window_table_bench;
  localparam int ADDR_W = 32;
  localparam int ENTRIES = 64;
  localparam int MAXC = 255;

  logic clk = 0, rst_n = 0, clear = 0;
  logic mstValid = 0, slvValid = 0, remValid = 0, remWrite = 0;
  logic [ADDR_W-1:0] mstAddr = '0, slvAddr = '0, remAddr = '0;
  logic mstStall, remAllow;

  int checks = 0, fails = 0, cycles = 0;
  int model [ENTRIES];

  always #10 clk = ~clk;

  access_window_table u_access_window_table (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .mstValid(mstValid), .mstAddr(mstAddr), .mstStall(mstStall),
    .slvValid(slvValid), .slvAddr(slvAddr),
    .remValid(remValid), .remAddr(remAddr), .remWrite(remWrite),
    .remAllow(remAllow)
  );

  function automatic int ix(input logic [ADDR_W-1:0] a);
    return int'(a[7:2]);  // R1 index bits
  endfunction

  // behavioural reference: committed on the rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      foreach (model[k]) model[k] = 0;
    end else begin
      int mi, si, delta_m, delta_s;
      mi = ix(mstAddr); si = ix(slvAddr);
      delta_m = (mstValid && model[mi] < MAXC) ? 1 : 0;
      delta_s = (slvValid && model[si] > 0) ? 1 : 0;
      model[mi] = model[mi] + delta_m;
      model[si] = model[si] - delta_s;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic mv, input logic [ADDR_W-1:0] ma,
                       input logic sv, input logic [ADDR_W-1:0] sa,
                       input logic rv, input logic [ADDR_W-1:0] ra, input logic rw,
                       input logic clr, input string tag);
    @(negedge clk);
    mstValid = mv; mstAddr = ma; slvValid = sv; slvAddr = sa;
    remValid = rv; remAddr = ra; remWrite = rw; clear = clr;
    #2;
    check(tag, mstStall, mv && model[ix(ma)] == MAXC, "mstStall");
    check(tag, remAllow, !(rv && rw && model[ix(ra)] != 0), "remAllow");
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  localparam logic [ADDR_W-1:0] A  = 32'h0000_0010;  // entry 4
  localparam logic [ADDR_W-1:0] AL = 32'h0000_1110;  // also entry 4 (R1 alias)
  localparam logic [ADDR_W-1:0] B  = 32'h0000_0020;  // entry 8

  initial begin
    // R9: reset state
    remValid = 1; remWrite = 1; remAddr = A; mstValid = 0;
    #35;
    check("R9", remAllow, 1'b1, "remAllow in reset");
    check("R9", mstStall, 1'b0, "mstStall in reset");
    rst_n = 1;
    idle("R9");
    drive(0, 0, 0, 0, 1, B, 1, 0, "R9");

    // R2/R4/R5: open a window with three master accesses
    for (int n = 0; n < 3; n++) drive(1, A, 0, 0, 1, A, 1, 0, "R2");
    drive(0, 0, 0, 0, 1, A, 1, 0, "R4");
    check("R4", remAllow, 1'b0, "write to open window");
    drive(0, 0, 0, 0, 1, A, 0, 0, "R5");
    check("R5", remAllow, 1'b1, "read to open window");
    drive(0, 0, 0, 0, 1, B, 1, 0, "R4");
    check("R4", remAllow, 1'b1, "write to closed entry");

    // R1: alias shares the counter
    drive(1, AL, 0, 0, 1, AL, 1, 0, "R1");
    check("R1", remAllow, 1'b0, "alias sees open window");
    // R3: slave drains via the alias address too; 4 decrements needed
    for (int n = 0; n < 3; n++) drive(0, 0, 1, (n == 1) ? AL : A, 1, A, 1, 0, "R3");
    drive(0, 0, 1, A, 1, A, 1, 0, "R3");
    check("R3", remAllow, 1'b0, "one left before last slave");
    drive(0, 0, 1, A, 1, A, 1, 0, "R3");
    check("R3", remAllow, 1'b1, "drained after extra slave ignored");
    // underflow: master once, then one slave must close it
    drive(1, A, 0, 0, 0, 0, 0, 0, "R3");
    drive(0, 0, 0, 0, 1, A, 1, 0, "R3");
    check("R3", remAllow, 1'b0, "no underflow");
    // R8: simultaneous master+slave keep count at 1
    drive(1, A, 1, A, 0, 0, 0, 0, "R8");
    drive(0, 0, 1, A, 1, A, 1, 0, "R8");
    check("R8", remAllow, 1'b0, "count still one");
    drive(0, 0, 0, 0, 1, A, 1, 0, "R8");
    check("R8", remAllow, 1'b1, "count now zero");

    // R6: saturation
    for (int n = 0; n < MAXC; n++) drive(1, B, 0, 0, 0, 0, 0, 0, "R6");
    drive(1, B, 0, 0, 0, 0, 0, 0, "R6");
    check("R6", mstStall, 1'b1, "stall at ceiling");
    drive(1, B, 1, B, 0, 0, 0, 0, "R6");
    check("R6", mstStall, 1'b1, "stall with slave same cycle");
    drive(1, B, 0, 0, 0, 0, 0, 0, "R6");
    check("R6", mstStall, 1'b0, "accepted after slave");
    drive(1, B, 0, 0, 0, 0, 0, 0, "R6");
    check("R6", mstStall, 1'b1, "full again");

    // R7: clear beats same-cycle master access
    drive(1, A, 0, 0, 0, 0, 0, 1, "R7");
    drive(1, B, 0, 0, 1, A, 1, 0, "R7");
    check("R7", mstStall, 1'b0, "cleared ceiling");
    check("R7", remAllow, 1'b1, "cleared window");
    drive(0, 0, 0, 0, 0, 0, 0, 1, "R7");

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] pool [5];
      pool[0] = A; pool[1] = AL; pool[2] = B; pool[3] = 32'h0000_0104; pool[4] = 32'h0000_0004;
      drive(($urandom % 3) != 0, pool[$urandom % 5],
            ($urandom % 2) != 0, pool[$urandom % 5],
            ($urandom % 4) != 0, pool[$urandom % 5], ($urandom % 2) != 0,
            ($urandom % 300) == 0, "R2");
    end

    finish_run();
  end
endmodule